// File: doc/BRIEF.md
# Interrupt Redirection Table Unit

This block sits between a bank of 24 interrupt input pins and one outgoing message port. Each pin owns a 64-bit redirection entry. Software writes and reads the entry as two 32-bit words. The entry sets these properties of the pin:

- the vector;
- the delivery mode;
- how the destination is read;
- the input polarity;
- edge or level triggering;
- a mask.

Two bits of the same entry hold status that only hardware can change. One marks a message still waiting to leave. The other marks a level message that a receiver has taken and not yet ended.

The unit turns each pin's level into an active-true signal using its polarity. It then detects an event and gates that event with the mask. A pin with an event is held pending. A fixed-priority arbiter picks the lowest-numbered pending pin and loads its fields into a registered valid/ready message port.

Level-triggered pins take part in an end-of-interrupt (EOI) handshake. Once a level message is accepted, the pin sends nothing more until an EOI with the same vector arrives on the EOI input. After that EOI, the pin sends again only if its input is still active.

Top module: `irq_redirect_unit`

## Requirements
- R1: After reset, every entry reads with the mask (low word bit 16) set and every other bit zero, and no message is offered.
- R2: Register word address = pin × 2 + half, where half 0 is the low word and half 1 is the high word. Read data is registered, so it appears one cycle after the read address. The low word layout is: vector 7:0, delivery mode 10:8, logical destination flag 11, pending status 12, polarity 13, remote-accept status 14, trigger mode 15, mask 16. The high word carries the destination in bits 31:24. All other bits read 0, and an address beyond the last pin reads 0.
- R3: Writes to bits 12 and 14 of the low word are ignored. Those bits only ever show hardware status.
- R4: With polarity 0 a pin is active high; with polarity 1 it is active low. An edge-mode pin (trigger bit 0) sends exactly one message for each change from inactive to active, however long the input then stays active.
- R5: While the mask is 1, a pin detects nothing. An activation that happens while the pin is masked is dropped, and clearing the mask later does not send it.
- R6: The pending status reads 1 from detection until the message handshake (valid and ready both high at a clock edge) completes. While valid is high and ready is low, all message fields hold steady.
- R7: For a level pin (trigger bit 1, delivery mode fixed 000 or lowest priority 001), the handshake sets remote-accept. While remote-accept is 1, the pin issues no further message. An EOI whose vector equals the entry's vector clears remote-accept. After that, a new message follows only if the input is still active.
- R8: An EOI carrying a vector that differs from the entry's vector leaves that entry unchanged.
- R9: Delivery modes 010, 100, 101 and 111 always behave as edge mode, even when the trigger bit is 1. They never set remote-accept and they send one message per activation.
- R10: The reserved delivery modes 011 and 110 never produce a message, and the pending status stays 0.
- R11: When several pins are pending, the lowest-numbered pin is offered first.
- R12: The message carries the entry's vector and delivery mode. With the logical flag at 0, the destination is {4'b0000, dest[3:0]}. With the logical flag at 1, the destination is the full dest[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Raw interrupt input pins |
| cfg_we | input | 1 | Write strobe for one 32-bit entry word |
| cfg_waddr | input | ADDR_W | Word address for the write: pin × 2 + half |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W | Word address for the read |
| cfg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The receiver takes the message |
| msg_vector | output | 8 | Vector of the message |
| msg_mode | output | 3 | Delivery mode of the message |
| msg_dest_mode | output | 1 | 0 for physical, 1 for logical destination |
| msg_dest | output | 8 | Destination of the message |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |

## Verification
Single pins are driven with one activation and then held active. This separates one message per edge from a repeated message. Active-high and active-low pins are both driven, which shows the polarity is applied before edge detection. A masked activation is followed by clearing the mask while the input is still active; any message at that point would mean the event was queued rather than dropped. A held level input is combined with a wrong-vector EOI, a right-vector EOI, and a right-vector EOI after the input has been withdrawn. These three cases separate the remote-accept gate from a plain level follower. Two pins raised together with the receiver stalled show the priority order and the hold rule, and a level-flagged NMI pin and a reserved-mode pin check the mode overrides.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int WORD_W = 32;

  // bit positions in the low word (software-visible layout)
  localparam int B_DMODE = 11;
  localparam int B_PEND  = 12;
  localparam int B_POL   = 13;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;
  localparam int B_DEST  = 24;   // in the high word

  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_RSV6   = 3'b110,
    DM_EXTINT = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              dst_logical;
    dmode_e            mode;
    logic [VEC_W-1:0]  vec;
  } rt_cfg_t;

  localparam rt_cfg_t CFG_RESET = '{dest: '0, mask: 1'b1, trig: 1'b0, pol: 1'b0,
                                    dst_logical: 1'b0, mode: DM_FIXED, vec: '0};

  function automatic logic mode_reserved(dmode_e m);
    return (m == DM_RSV3) || (m == DM_RSV6);
  endfunction

  // only fixed and lowest-priority honour level triggering
  function automatic logic mode_level_ok(dmode_e m);
    return (m == DM_FIXED) || (m == DM_LOWPRI);
  endfunction
endpackage

// File: rtl/irq_rt_pin.sv
module irq_rt_pin
  import irq_rt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  rt_cfg_t          cfg,
  input  logic             sent,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             pend,
  output logic             rirr
);
  logic act_now, act_q, level_eff, rise, detect, eoi_hit;

  assign act_now   = raw_in ^ cfg.pol;
  assign level_eff = cfg.trig & mode_level_ok(cfg.mode);
  assign rise      = act_now & ~act_q;
  assign eoi_hit   = eoi_valid && (eoi_vector == cfg.vec);

  always_comb begin
    if (cfg.mask || mode_reserved(cfg.mode))
      detect = 1'b0;
    else if (level_eff)
      detect = act_now & ~rirr & ~pend;
    else
      detect = rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      pend  <= 1'b0;
      rirr  <= 1'b0;
    end else begin
      act_q <= act_now;
      if (sent)        pend <= 1'b0;
      else if (detect) pend <= 1'b1;
      if (sent)             rirr <= level_eff;
      else if (!level_eff)  rirr <= 1'b0;
      else if (eoi_hit)     rirr <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_rt_arb.sv
module irq_rt_arb #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/irq_redirect_unit.sv
module irq_redirect_unit
  import irq_rt_pkg::*;
#(
  parameter  int NUM_PINS = 24,
  localparam int PIN_W    = $clog2(NUM_PINS),
  localparam int ADDR_W   = PIN_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_waddr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  input  logic [ADDR_W-1:0]   cfg_raddr,
  output logic [WORD_W-1:0]   cfg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [VEC_W-1:0]    msg_vector,
  output logic [2:0]          msg_mode,
  output logic                msg_dest_mode,
  output logic [DEST_W-1:0]   msg_dest,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector
);
  localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

  rt_cfg_t             cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0] pend_vec, rirr_vec, sent_vec;
  logic [PIN_W-1:0]    wpin, rpin, msg_pin, arb_idx;
  logic                wok, rok, fire, arb_any;
  logic                unused_wbits;

  assign wpin  = cfg_waddr[ADDR_W-1:1];
  assign rpin  = cfg_raddr[ADDR_W-1:1];
  assign wok   = cfg_we && (wpin <= LAST_PIN);
  assign rok   = (rpin <= LAST_PIN);
  assign fire  = msg_valid && msg_ready;
  assign unused_wbits = ^{cfg_wdata[23:17], cfg_wdata[B_RIRR], cfg_wdata[B_PEND]};

  // entry storage: status bits are never written from software
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rst) begin
        cfg_q[p] <= CFG_RESET;
      end else if (wok && wpin == PIN_W'(p)) begin
        if (!cfg_waddr[0]) begin
          cfg_q[p].vec         <= cfg_wdata[VEC_W-1:0];
          cfg_q[p].mode        <= dmode_e'(cfg_wdata[10:8]);
          cfg_q[p].dst_logical <= cfg_wdata[B_DMODE];
          cfg_q[p].pol         <= cfg_wdata[B_POL];
          cfg_q[p].trig        <= cfg_wdata[B_TRIG];
          cfg_q[p].mask        <= cfg_wdata[B_MASK];
        end else begin
          cfg_q[p].dest        <= cfg_wdata[WORD_W-1:B_DEST];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign sent_vec[g] = fire && (msg_pin == PIN_W'(g));
    irq_rt_pin u_pin (
      .clk        (clk),
      .rst        (rst),
      .raw_in     (irq_in[g]),
      .cfg        (cfg_q[g]),
      .sent       (sent_vec[g]),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .pend       (pend_vec[g]),
      .rirr       (rirr_vec[g])
    );
  end

  irq_rt_arb #(.N(NUM_PINS), .IDX_W(PIN_W)) u_arb (
    .req (pend_vec),
    .any (arb_any),
    .idx (arb_idx)
  );

  // registered message port; a new pin is loaded only when the slot is empty
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid     <= 1'b0;
      msg_pin       <= '0;
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_dest_mode <= 1'b0;
      msg_dest      <= '0;
    end else if (fire) begin
      msg_valid     <= 1'b0;
    end else if (!msg_valid && arb_any) begin
      msg_valid     <= 1'b1;
      msg_pin       <= arb_idx;
      msg_vector    <= cfg_q[arb_idx].vec;
      msg_mode      <= cfg_q[arb_idx].mode;
      msg_dest_mode <= cfg_q[arb_idx].dst_logical;
      msg_dest      <= cfg_q[arb_idx].dst_logical ? cfg_q[arb_idx].dest
                                                  : {4'b0000, cfg_q[arb_idx].dest[3:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rok) begin
      cfg_rdata <= '0;
    end else if (cfg_raddr[0]) begin
      cfg_rdata <= {cfg_q[rpin].dest, 24'b0};
    end else begin
      cfg_rdata <= {15'b0, cfg_q[rpin].mask, cfg_q[rpin].trig, rirr_vec[rpin],
                    cfg_q[rpin].pol, pend_vec[rpin], cfg_q[rpin].dst_logical,
                    cfg_q[rpin].mode, cfg_q[rpin].vec};
    end
  end
endmodule

// File: rtl/irq_rt_checker.sv
module irq_rt_checker #(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                msg_valid,
  input logic                msg_ready,
  input logic [7:0]          msg_vector,
  input logic [2:0]          msg_mode,
  input logic                msg_dest_mode,
  input logic [7:0]          msg_dest,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] rirr_vec
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_mode)
                               && $stable(msg_dest) && $stable(msg_dest_mode));

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_vec) < $past($countones(pend_vec)) |-> $past(msg_valid && msg_ready));

  assert_rirr_set_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(rirr_vec) > $past($countones(rirr_vec)) |-> $past(msg_valid && msg_ready));

  assert_no_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_mode != 3'b011) && (msg_mode != 3'b110));

  assert_phys_dest_R12: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_dest_mode |-> msg_dest[7:4] == 4'b0000);

  assert_offer_source_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(|pend_vec));
endmodule

bind irq_redirect_unit irq_rt_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_vector    (msg_vector),
  .msg_mode      (msg_mode),
  .msg_dest_mode (msg_dest_mode),
  .msg_dest      (msg_dest),
  .pend_vec      (pend_vec),
  .rirr_vec      (rirr_vec)
);

// File: tb/irq_redirect_unit_test.sv
`timescale 1ns/1ps
module irq_redirect_unit_test;
  localparam int NP = 24;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_waddr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [AW-1:0] cfg_raddr = '0;
  logic [31:0]   cfg_rdata;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [7:0]    msg_vector;
  logic [2:0]    msg_mode;
  logic          msg_dest_mode;
  logic [7:0]    msg_dest;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;

  int checks = 0;
  int errors = 0;
  int msg_cnt = 0;
  logic [7:0] last_vec, last_dest;
  logic [2:0] last_mode;

  irq_redirect_unit uut (.*);

  always #10 clk = ~clk;

  // handshake monitor, sampled half a period from the active edge
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      msg_cnt   = msg_cnt + 1;
      last_vec  = msg_vector;
      last_dest = msg_dest;
      last_mode = msg_mode;
    end
  end

  // table: pin, low word written, high word written, low expected, high expected
  localparam int NROWS = 4;
  localparam logic [132:0] ROWS [NROWS] = '{
    {5'd13, 32'h0001_5F23, 32'hC3FF_FFFF, 32'h0001_0F23, 32'hC300_0000},
    {5'd14, 32'h0001_A0FE, 32'h0000_0000, 32'h0001_A0FE, 32'h0000_0000},
    {5'd15, 32'hFFFE_0010, 32'h1234_5678, 32'h0000_0010, 32'h1200_0000},
    {5'd23, 32'h0001_7100, 32'hFF00_0000, 32'h0001_2100, 32'hFF00_0000}
  };

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic wait_n(int n);
    repeat (n) tick();
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    cfg_raddr = a;
    tick();
    d = cfg_rdata;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick();
    eoi_valid = 1'b0;
  endtask

  function automatic logic [31:0] lo(logic mask, logic trig, logic pol, logic dl,
                                     logic [2:0] mode, logic [7:0] vec);
    return {15'b0, mask, trig, 1'b0, pol, 1'b0, dl, mode, vec};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    wait_n(3);
    rst = 1'b0;
    tick();

    // R1: reset state
    rd(AW'(0), r);  chk("R1 pin0 low", r, 32'h0001_0000);
    rd(AW'(47), r); chk("R1 pin23 high", r, 32'h0);
    chk("R1 no message", {31'b0, msg_valid}, 32'h0);

    // R2/R3: table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [4:0] p;
      p = ROWS[i][132:128];
      wr({p, 1'b0}, ROWS[i][127:96]);
      wr({p, 1'b1}, ROWS[i][95:64]);
      rd({p, 1'b0}, r); chk("R3 low readback", r, ROWS[i][63:32]);
      rd({p, 1'b1}, r); chk("R2 high readback", r, ROWS[i][31:0]);
    end
    rd(AW'(48), r); chk("R2 out of range", r, 32'h0);

    // R4/R12: edge, active high, physical destination
    wr(AW'(7), 32'hA500_0000);
    wr(AW'(6), lo(0, 0, 0, 0, 3'b000, 8'h31));
    base = msg_cnt;
    irq_in[3] = 1'b1;
    wait_n(4);
    chk("R4 edge message", msg_cnt - base, 1);
    chk("R12 vector", last_vec, 8'h31);
    chk("R12 physical dest", last_dest, 8'h05);
    wait_n(6);
    chk("R4 held input sends once", msg_cnt - base, 1);

    // R12: logical destination
    wr(AW'(9), 32'hA500_0000);
    wr(AW'(8), lo(0, 0, 0, 1, 3'b001, 8'h44));
    irq_in[4] = 1'b1;
    wait_n(4);
    chk("R12 logical dest", last_dest, 8'hA5);
    chk("R12 mode", last_mode, 3'b001);

    // R4: active low
    irq_in[5] = 1'b1;
    tick();
    wr(AW'(10), lo(0, 0, 1, 0, 3'b000, 8'h35));
    tick();
    base = msg_cnt;
    wait_n(4);
    chk("R4 inactive low pin quiet", msg_cnt - base, 0);
    irq_in[5] = 1'b0;
    wait_n(4);
    chk("R4 active low edge", msg_cnt - base, 1);

    // R5: masked activation dropped
    wr(AW'(12), lo(1, 0, 0, 0, 3'b000, 8'h36));
    base = msg_cnt;
    irq_in[6] = 1'b1;
    wait_n(3);
    wr(AW'(12), lo(0, 0, 0, 0, 3'b000, 8'h36));
    wait_n(5);
    chk("R5 masked edge dropped", msg_cnt - base, 0);
    irq_in[6] = 1'b0;
    tick();
    irq_in[6] = 1'b1;
    wait_n(4);
    chk("R5 unmasked edge sent", msg_cnt - base, 1);

    // R6: pending held while stalled
    msg_ready = 1'b0;
    wr(AW'(14), lo(0, 0, 0, 0, 3'b000, 8'h37));
    irq_in[7] = 1'b1;
    wait_n(3);
    chk("R6 valid while stalled", {31'b0, msg_valid}, 32'h1);
    rd(AW'(14), r); chk("R6 pending status", r, lo(0, 0, 0, 0, 3'b000, 8'h37) | 32'h1000);
    wait_n(3);
    chk("R6 vector held", msg_vector, 8'h37);
    base = msg_cnt;
    msg_ready = 1'b1;
    wait_n(3);
    chk("R6 handshake", msg_cnt - base, 1);
    rd(AW'(14), r); chk("R6 pending cleared", r, lo(0, 0, 0, 0, 3'b000, 8'h37));

    // R7/R8: level with EOI
    base = msg_cnt;
    irq_in[8] = 1'b1;
    wr(AW'(16), lo(0, 1, 0, 0, 3'b000, 8'h48));
    wait_n(5);
    chk("R7 level message", msg_cnt - base, 1);
    rd(AW'(16), r); chk("R7 remote accept set", r, 32'h0000_C048);
    wait_n(5);
    chk("R7 blocked while accepted", msg_cnt - base, 1);
    eoi(8'h49);
    wait_n(4);
    chk("R8 wrong EOI no resend", msg_cnt - base, 1);
    rd(AW'(16), r); chk("R8 wrong EOI keeps state", r, 32'h0000_C048);
    eoi(8'h48);
    wait_n(5);
    chk("R7 resend after EOI", msg_cnt - base, 2);
    irq_in[8] = 1'b0;
    tick();
    eoi(8'h48);
    wait_n(5);
    chk("R7 no resend when idle", msg_cnt - base, 2);
    rd(AW'(16), r); chk("R7 remote accept cleared", r, 32'h0000_8048);

    // R9: NMI with level bit behaves as edge
    wr(AW'(18), lo(0, 1, 0, 0, 3'b100, 8'h00));
    base = msg_cnt;
    irq_in[9] = 1'b1;
    wait_n(4);
    chk("R9 NMI message", msg_cnt - base, 1);
    chk("R9 NMI mode", last_mode, 3'b100);
    rd(AW'(18), r); chk("R9 no remote accept", r, lo(0, 1, 0, 0, 3'b100, 8'h00));
    wait_n(5);
    chk("R9 single message", msg_cnt - base, 1);

    // R10: reserved mode
    wr(AW'(20), lo(0, 0, 0, 0, 3'b110, 8'h3A));
    base = msg_cnt;
    irq_in[10] = 1'b1;
    wait_n(5);
    chk("R10 reserved silent", msg_cnt - base, 0);
    rd(AW'(20), r); chk("R10 no pending", r, lo(0, 0, 0, 0, 3'b110, 8'h3A));

    // R11: priority
    wr(AW'(22), lo(0, 0, 0, 0, 3'b000, 8'h5B));
    wr(AW'(24), lo(0, 0, 0, 0, 3'b000, 8'h5C));
    msg_ready = 1'b0;
    base = msg_cnt;
    irq_in[12] = 1'b1;
    irq_in[11] = 1'b1;
    wait_n(3);
    chk("R11 lowest pin first", msg_vector, 8'h5B);
    rd(AW'(24), r); chk("R11 other pin pending", r, lo(0, 0, 0, 0, 3'b000, 8'h5C) | 32'h1000);
    msg_ready = 1'b1;
    wait_n(6);
    chk("R11 both sent", msg_cnt - base, 2);
    chk("R11 second vector", last_vec, 8'h5C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule